// File: doc/BRIEF.md
# Prescaled One-Shot / Periodic Countdown Timer

This block is the countdown timer of a local interrupt controller. A free-running clock is divided by a power of two selected through a 3-bit shift amount. Every `2^shift` clock cycles the timer registers one elapsed count. Software starts the timer by writing a 32-bit initial count. That write also marks the load point from which all elapsed counts are measured.

The timer runs in one of two modes. In one-shot mode the count runs down to zero, stays there, and raises a single expiry one count later. In periodic mode the count reloads from the initial value every `initial+1` counts and raises an expiry on each reload. A periodic timer loaded with zero never expires. A mask input blocks expiry pulses. The live count is presented on an output so that register reads can use it.

Top module: `cd_timer`

## Requirements
- R1: After reset the count output reads 0, and no expiry pulse occurs until the first load.
- R2: A load (`load_i` high at a clock edge) sets `count_o` to `load_val_i` in the next cycle, for any 32-bit value.
- R3: Elapsed counts equal the clock cycles since the load edge, shifted right by `shift_i` (0 gives divide-by-1, 7 gives divide-by-128). `count_o` drops by one on each elapsed count.
- R4: One-shot mode (`periodic_i` = 0) behaves as follows. `count_o` reads initial minus elapsed, then holds at 0 once elapsed reaches the initial value. Exactly one expiry occurs, in the cycle where elapsed first equals initial+1.
- R5: In periodic mode (`periodic_i` = 1) with a nonzero initial value, `count_o` reads initial minus (elapsed mod (initial+1)). An expiry occurs in every cycle where elapsed reaches a nonzero multiple of initial+1.
- R6: In periodic mode with an initial value of 0, `count_o` stays 0 and no expiry ever occurs.
- R7: When `mask_i` is high at the edge where an expiry would be produced, no pulse appears. A one-shot expiry suppressed this way is not delivered after unmasking.
- R8: `expire_o` is high for a single cycle per expiry.
- R9: A load while the timer is running discards the old run and restarts counting and the prescale phase from the new load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running tick clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shift_i | input | 3 | Prescale shift amount (divide by 2^shift) |
| periodic_i | input | 1 | 1 = periodic mode, 0 = one-shot mode |
| mask_i | input | 1 | Suppress expiry pulses |
| load_i | input | 1 | Write strobe for the initial count |
| load_val_i | input | 32 | Initial count value |
| count_o | output | 32 | Current count |
| expire_o | output | 1 | Single-cycle expiry pulse |

## Verification
The hardest case to reach is a one-shot expiry that falls due while masked, followed by unmasking without a new load. The timer must stay silent even though its count reads zero and its mode would allow a pulse. The bench loads a short one-shot count with the mask set and runs past the due point. It then clears the mask mid-run and keeps observing `expire_o` for several more prescaled counts. A second hard case is reloading a running periodic timer in the middle of a period. This is reached by issuing a fresh load a few cycles into a long period and checking that the new phase starts at that edge.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned TICK_W  = 40;
  localparam int unsigned SHIFT_W = 3;
  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [SHIFT_W-1:0] shift_t;
endpackage

// File: rtl/ct_prescale.sv
module ct_prescale #(
  parameter int unsigned TICK_W  = 40,
  parameter int unsigned SHIFT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               step_o
);
  logic [TICK_W-1:0] delta_q, delta_nx, low_mask;

  // ticks elapsed since the load edge
  assign delta_nx = delta_q + TICK_W'(1);
  assign low_mask = ~({TICK_W{1'b1}} << shift_i);
  assign step_o   = !restart_i && ((delta_nx & low_mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        delta_q <= '0;
    else if (restart_i) delta_q <= '0;
    else                delta_q <= delta_nx;
  end
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] init_q, init_d, cur_q, cur_d;
  logic             done_q, done_d;

  always_comb begin
    init_d = init_q;
    cur_d  = cur_q;
    done_d = done_q;
    fire_o = 1'b0;
    if (restart_i) begin
      init_d = load_val_i;
      cur_d  = load_val_i;
      done_d = 1'b0;
    end else if (step_i) begin
      if (cur_q != '0) begin
        cur_d = cur_q - CNT_W'(1);
      end else if (periodic_i) begin
        cur_d  = init_q;
        fire_o = (init_q != '0);
      end else begin
        fire_o = !done_q;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      cur_q  <= '0;
      done_q <= 1'b1; // nothing scheduled until first load
    end else begin
      init_q <= init_d;
      cur_q  <= cur_d;
      done_q <= done_d;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/ct_expiry.sv
module ct_expiry (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic mask_i,
  output logic pulse_o
);
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= fire_i & !mask_i;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/cd_timer.sv
module cd_timer
  import ct_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   shift_i,
  input  logic         periodic_i,
  input  logic         mask_i,
  input  logic         load_i,
  input  logic [31:0]  load_val_i,
  output logic [31:0]  count_o,
  output logic         expire_o
);
  logic step, fire;

  ct_prescale #(.TICK_W(TICK_W), .SHIFT_W(SHIFT_W)) i_prescale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load_i),
    .shift_i   (shift_i),
    .step_o    (step)
  );

  ct_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (load_i),
    .load_val_i (load_val_i),
    .step_i     (step),
    .periodic_i (periodic_i),
    .cur_o      (count_o),
    .fire_o     (fire)
  );

  ct_expiry i_expiry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .mask_i  (mask_i),
    .pulse_o (expire_o)
  );
endmodule

// File: rtl/cd_timer_chk.sv
module cd_timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        periodic_i,
  input logic        mask_i,
  input logic        load_i,
  input logic [31:0] load_val_i,
  input logic [31:0] count_o,
  input logic        expire_o
);
  AST_LOAD_SETS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i)); // R2

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o); // R8

  AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> !$past(mask_i)); // R7

  AST_FIRE_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(count_o) == 32'd0); // R5

  AST_ONESHOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!periodic_i && !load_i && count_o == 32'd0) |=> count_o == 32'd0); // R4
endmodule

bind cd_timer cd_timer_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .periodic_i (periodic_i),
  .mask_i     (mask_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .count_o    (count_o),
  .expire_o   (expire_o)
);

// File: tb/test_cd_timer.sv
`timescale 1ns/1ps
module test_cd_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  shift_i = '0;
  logic        periodic_i = 1'b0;
  logic        mask_i = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] load_val_i = '0;
  logic [31:0] count_o;
  logic        expire_o;

  typedef struct {
    longint unsigned cnt;
    bit              exp;
    string           tag;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  longint unsigned g_init = 0, g_k = 0;
  int  g_shift = 0;
  bit  g_per = 0, g_noload = 1, m_edge = 0;

  cd_timer i_cd_timer (.*);

  always #2.5 clk_i = ~clk_i;

  // monitor
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      n_chk++;
      if (count_o !== it.cnt[31:0] || expire_o !== it.exp) begin
        n_bad++;
        $display("FAIL %s: count=%0d expire=%0b, expected count=%0d expire=%0b",
                 it.tag, count_o, expire_o, it.cnt, it.exp);
      end
    end
  end

  function automatic item_t model(longint unsigned k, bit m, string tag);
    item_t r;
    longint unsigned d, msk, p;
    bit edge_step;
    d = k >> g_shift;
    msk = (longint'(1) << g_shift) - 1;
    edge_step = (k > 0) && ((k & msk) == 0);
    r.tag = tag;
    r.exp = 0;
    if (g_noload) begin
      r.cnt = 0;
    end else if (g_per) begin
      if (g_init == 0) r.cnt = 0;
      else begin
        p = g_init + 1;
        r.cnt = g_init - (d % p);
        r.exp = edge_step && (d % p == 0) && !m;
      end
    end else begin
      r.cnt = (d >= g_init) ? 0 : g_init - d;
      r.exp = edge_step && (d == g_init + 1) && !m;
    end
    return r;
  endfunction

  // driver: called at posedge+1
  task automatic start(longint unsigned init, int sh, bit per, bit msk);
    load_val_i = init[31:0];
    shift_i = sh[2:0];
    periodic_i = per;
    mask_i = msk;
    load_i = 1'b1;
    @(posedge clk_i);
    m_edge = mask_i;
    #1;
    load_i = 1'b0;
    g_init = init; g_shift = sh; g_per = per; g_noload = 0; g_k = 0;
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model(g_k, m_edge, tag));
      @(posedge clk_i);
      m_edge = mask_i;
      #1;
      g_k++;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    run(6, "R1");                       // reset state, no pulse
    start(32'hFFFF_FFFF, 7, 0, 0);       // R2 full-width load
    run(3, "R2");
    start(5, 0, 0, 0);  run(10, "R4");   // one-shot, divide-by-1
    start(3, 2, 0, 0);  run(25, "R3");   // one-shot, divide-by-4
    start(0, 0, 0, 0);  run(5, "R4");    // one-shot zero: fires one count later
    start(3, 1, 1, 0);  run(30, "R5");   // periodic, divide-by-2
    start(2, 0, 1, 0);  run(12, "R8");   // back-to-back periods
    start(0, 0, 1, 0);  run(10, "R6");   // periodic zero never fires
    start(2, 0, 0, 1);  run(6, "R7");    // masked one-shot passes due point
    mask_i = 1'b0;      run(8, "R7");    // unmask: still silent
    start(1, 0, 1, 1);  run(6, "R7");    // masked periodic
    mask_i = 1'b0;      run(6, "R7");    // unmasked resumes
    start(10, 0, 1, 0); run(4, "R9");
    start(2, 1, 1, 0);  run(14, "R9");   // reload mid-period
    wait (exp_q.size() == 0);
    @(posedge clk_i);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule